// File: doc/BRIEF.md
# Lane Comma Alignment and Sync Request Controller

This block brings up the receive side of one 8b/10b serial lane. A deserializer hands it one raw 10-bit word per clock, with no knowledge of where the encoded characters begin. The block holds an active-low synchronization request toward the transmitter. It asks for this request only once the link is enabled and the local multiframe clock has been marked valid. While the request is active, the transmitter sends a continuous stream of K28.5 comma characters. The block searches every bit offset for that comma and locks onto the first offset where one appears.

Once the comma has been seen four times in a row at the locked offset, the character boundary is trusted. The block raises a done flag, but it keeps the request asserted until the next local multiframe clock boundary arrives. At that boundary it releases the request and waits for the transmitter's initial lane alignment sequence. From the moment of lock, the block presents aligned 10-bit characters and the selected bit offset. Decoding, checking of the alignment sequence and lane deskew belong to later stages.

Top module: `cgs_lane_sync`

## Requirements
- R1: The block stays in the idle state (`dbg_state` = 0) until `link_en` and `lmfc_valid` are both high at a clock edge. At that edge it moves to the search state (`dbg_state` = 1).
- R2: `sync_n` is 0 in every state except the ILAS-wait state (`dbg_state` = 4).
- R3: Comma detection forms a 20-bit window {previous word, current word}. The bit received first is the MSB of each word. The candidate at offset k (0..9) is window bits [19-k:10-k]. It matches if it equals 0011111010 or 1100000101. When several offsets match, the lowest one wins. A comma that lies wholly in word n is therefore seen at offset 0 at the edge where word n+1 is presented.
- R4: `aligned_char` is registered and equals the candidate at the offset in force after that edge.
- R5: After the fourth consecutive comma at the locked offset, the block enters the LMFC-wait state (`dbg_state` = 3) and raises `cgs_done`. `sync_n` stays 0 until an edge at which `lmfc_edge` is high.
- R6: In the count state (`dbg_state` = 2), a word with no comma resets the run count to zero. Four new consecutive commas are then needed.
- R7: In the count state, a comma at a different offset, with none at the locked offset, moves `align_ofs` to the new offset and resets the run count to zero.
- R8: In the LMFC-wait state, an edge with `lmfc_edge` high moves the block to the ILAS-wait state. There `sync_n` = 1 and `ilas_wait` = 1, and the block remains while `link_en` stays high.
- R9: `link_en` low or `rst` high at an edge returns the block to the idle state, with `sync_n`, `cgs_done` and `ilas_wait` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Enables link bring-up; low forces idle |
| lmfc_valid | input | 1 | Local multiframe clock has been deterministically reset |
| lmfc_edge | input | 1 | One-cycle pulse on a multiframe boundary |
| rx_word | input | 10 | Unaligned word from the deserializer, first bit in MSB |
| sync_n | output | 1 | Active-low synchronization request to the transmitter |
| aligned_char | output | 10 | Character at the selected bit offset |
| align_ofs | output | 4 | Selected bit offset |
| cgs_done | output | 1 | Character synchronization achieved |
| ilas_wait | output | 1 | Request released, waiting for the alignment sequence |
| dbg_state | output | 3 | Current state: 0 idle, 1 search, 2 count, 3 LMFC wait, 4 ILAS wait |

## Verification
Faults in the run counter show up at the ports as `cgs_done` rising one word too early or too late. The bench catches this by sampling the edge just before the fourth aligned comma is counted and the edge on which it is counted. A wrong offset shows up on `align_ofs` and `aligned_char` in the same cycle the lock happens, and each of the ten offsets is swept with both comma disparities. If the state machine releases the request before its time, `sync_n` goes high during the hold cycles that come before the multiframe pulse.

// File: rtl/cgs_pkg.sv
`timescale 1ns/1ps
package cgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SEARCH    = 3'd1,
    ST_COUNT     = 3'd2,
    ST_WAIT_LMFC = 3'd3,
    ST_WAIT_ILAS = 3'd4
  } cgs_state_e;

  localparam int CHAR_BITS = 10;
  localparam logic [CHAR_BITS-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [CHAR_BITS-1:0] COMMA_POS = 10'b1100000101;
endpackage

// File: rtl/cgs_comma_scan.sv
`timescale 1ns/1ps
module cgs_comma_scan #(
  parameter int CHAR_W = 10,
  parameter int OFS_W  = 4,
  parameter logic [CHAR_W-1:0] PAT_A = '0,
  parameter logic [CHAR_W-1:0] PAT_B = '0
) (
  input  logic [2*CHAR_W-1:0]             win,
  output logic [CHAR_W-1:0][CHAR_W-1:0]   cand,
  output logic [CHAR_W-1:0]               hit,
  output logic                            any_hit,
  output logic [OFS_W-1:0]                first_ofs
);
  // one candidate slice and one comparator per bit offset
  for (genvar k = 0; k < CHAR_W; k++) begin : g_ofs
    assign cand[k] = win[2*CHAR_W-1-k -: CHAR_W];
    assign hit[k]  = (cand[k] == PAT_A) || (cand[k] == PAT_B);
  end

  assign any_hit = |hit;

  // lowest matching offset has priority
  always_comb begin
    first_ofs = '0;
    for (int k = CHAR_W - 1; k >= 0; k--) begin
      if (hit[k]) first_ofs = OFS_W'(k);
    end
  end
endmodule

// File: rtl/cgs_link_fsm.sv
`timescale 1ns/1ps
module cgs_link_fsm
  import cgs_pkg::*;
#(
  parameter int CHAR_W  = 10,
  parameter int OFS_W   = 4,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_en,
  input  logic              lmfc_valid,
  input  logic              lmfc_edge,
  input  logic [CHAR_W-1:0] hit,
  input  logic              any_hit,
  input  logic [OFS_W-1:0]  first_ofs,
  output cgs_state_e        state_q,
  output cgs_state_e        state_d,
  output logic [OFS_W-1:0]  ofs_d
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OFS_W-1:0] ofs_q;

  always_comb begin
    state_d = state_q;
    ofs_d   = ofs_q;
    cnt_d   = cnt_q;
    if (!link_en) begin
      state_d = ST_IDLE;
      ofs_d   = '0;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (lmfc_valid) state_d = ST_SEARCH;
        end
        ST_SEARCH: begin
          if (any_hit) begin
            ofs_d   = first_ofs;
            cnt_d   = CNT_W'(1);
            state_d = ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (hit[ofs_q]) begin
            if (cnt_q == CNT_W'(RUN_LEN - 1)) begin
              cnt_d   = CNT_W'(RUN_LEN);
              state_d = ST_WAIT_LMFC;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end else if (any_hit) begin
            ofs_d = first_ofs;
            cnt_d = '0;
          end else begin
            cnt_d = '0;
          end
        end
        ST_WAIT_LMFC: begin
          if (lmfc_edge) state_d = ST_WAIT_ILAS;
        end
        ST_WAIT_ILAS: state_d = ST_WAIT_ILAS;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ofs_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      ofs_q   <= ofs_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/cgs_lane_sync.sv
`timescale 1ns/1ps
module cgs_lane_sync
  import cgs_pkg::*;
#(
  parameter int CHAR_W  = CHAR_BITS,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_en,
  input  logic              lmfc_valid,
  input  logic              lmfc_edge,
  input  logic [CHAR_W-1:0] rx_word,
  output logic              sync_n,
  output logic [CHAR_W-1:0] aligned_char,
  output logic [3:0]        align_ofs,
  output logic              cgs_done,
  output logic              ilas_wait,
  output logic [2:0]        dbg_state
);
  localparam int OFS_W = 4;

  logic [CHAR_W-1:0]             prev_q;
  logic [2*CHAR_W-1:0]           win;
  logic [CHAR_W-1:0][CHAR_W-1:0] cand;
  logic [CHAR_W-1:0]             hit;
  logic                          any_hit;
  logic [OFS_W-1:0]              first_ofs;
  logic [OFS_W-1:0]              ofs_d;
  cgs_state_e                    state_q, state_d;

  assign win = {prev_q, rx_word};

  cgs_comma_scan #(
    .CHAR_W(CHAR_W), .OFS_W(OFS_W), .PAT_A(COMMA_NEG), .PAT_B(COMMA_POS)
  ) u_scan (
    .win(win), .cand(cand), .hit(hit), .any_hit(any_hit), .first_ofs(first_ofs)
  );

  cgs_link_fsm #(
    .CHAR_W(CHAR_W), .OFS_W(OFS_W), .RUN_LEN(RUN_LEN)
  ) u_fsm (
    .clk(clk), .rst(rst), .link_en(link_en), .lmfc_valid(lmfc_valid),
    .lmfc_edge(lmfc_edge), .hit(hit), .any_hit(any_hit), .first_ofs(first_ofs),
    .state_q(state_q), .state_d(state_d), .ofs_d(ofs_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q       <= '0;
      sync_n       <= 1'b0;
      cgs_done     <= 1'b0;
      ilas_wait    <= 1'b0;
      aligned_char <= '0;
      align_ofs    <= '0;
    end else begin
      prev_q       <= rx_word;
      sync_n       <= (state_d == ST_WAIT_ILAS);
      ilas_wait    <= (state_d == ST_WAIT_ILAS);
      cgs_done     <= (state_d == ST_WAIT_LMFC) || (state_d == ST_WAIT_ILAS);
      aligned_char <= cand[ofs_d];
      align_ofs    <= ofs_d;
    end
  end

  assign dbg_state = state_q;
endmodule

// File: rtl/cgs_lane_sync_chk.sv
`timescale 1ns/1ps
module cgs_lane_sync_chk
  import cgs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       link_en,
  input logic       lmfc_valid,
  input logic       lmfc_edge,
  input logic       sync_n,
  input logic [3:0] align_ofs,
  input logic       cgs_done,
  input logic       ilas_wait,
  input logic [2:0] dbg_state
);
  assert_entry_needs_lmfc_R1: assert property (@(posedge clk) disable iff (rst)
    (dbg_state == ST_SEARCH && $past(dbg_state) == ST_IDLE) |-> $past(lmfc_valid && link_en));

  assert_sync_low_R2: assert property (@(posedge clk) disable iff (rst)
    (dbg_state != ST_WAIT_ILAS) |-> !sync_n);

  assert_done_from_count_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cgs_done) |-> ($past(dbg_state) == ST_COUNT));

  assert_ofs_range_R7: assert property (@(posedge clk) disable iff (rst)
    align_ofs < 4'd10);

  assert_release_on_lmfc_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> ($past(lmfc_edge) && $past(cgs_done)));

  assert_ilas_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ilas_wait && link_en) |=> ilas_wait);

  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !link_en |=> (dbg_state == ST_IDLE && !sync_n && !cgs_done && !ilas_wait));
endmodule

bind cgs_lane_sync cgs_lane_sync_chk u_chk (
  .clk(clk), .rst(rst), .link_en(link_en), .lmfc_valid(lmfc_valid),
  .lmfc_edge(lmfc_edge), .sync_n(sync_n), .align_ofs(align_ofs),
  .cgs_done(cgs_done), .ilas_wait(ilas_wait), .dbg_state(dbg_state)
);

// File: tb/cgs_lane_sync_bench.sv
`timescale 1ns/1ps
module cgs_lane_sync_bench;
  localparam logic [9:0] KN = 10'b0011111010;
  localparam logic [9:0] KP = 10'b1100000101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       link_en = 1'b0;
  logic       lmfc_valid = 1'b0;
  logic       lmfc_edge = 1'b0;
  logic [9:0] rx_word = '0;
  logic       sync_n, cgs_done, ilas_wait;
  logic [9:0] aligned_char;
  logic [3:0] align_ofs;
  logic [2:0] dbg_state;

  int checks = 0;
  int fails  = 0;
  bit strm [0:511];

  always #10 clk = ~clk;

  cgs_lane_sync u_cgs_lane_sync (
    .clk(clk), .rst(rst), .link_en(link_en), .lmfc_valid(lmfc_valid),
    .lmfc_edge(lmfc_edge), .rx_word(rx_word), .sync_n(sync_n),
    .aligned_char(aligned_char), .align_ofs(align_ofs), .cgs_done(cgs_done),
    .ilas_wait(ilas_wait), .dbg_state(dbg_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic [9:0] w);
    rx_word = w;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [9:0] comma_of(input int m, input int d);
    return (((m + d) % 2) == 0) ? KN : KP;
  endfunction

  task automatic clear_stream();
    for (int i = 0; i < 512; i++) strm[i] = 1'b0;
  endtask

  task automatic put_char(input int pos, input logic [9:0] ch);
    for (int i = 0; i < 10; i++) strm[pos + i] = ch[9 - i];
  endtask

  function automatic logic [9:0] word_at(input int n);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[9 - i] = strm[10 * n + i];
    return w;
  endfunction

  task automatic restart();
    rst = 1'b1; link_en = 1'b0; lmfc_valid = 1'b0; lmfc_edge = 1'b0;
    tick(10'd0); tick(10'd0);
    rst = 1'b0; link_en = 1'b1; lmfc_valid = 1'b1;
    tick(10'd0); // idle -> search
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // reset state
    tick(10'd0); tick(10'd0);
    chk(dbg_state == 3'd0, "R9 reset state", dbg_state, 0);
    chk(sync_n == 1'b0, "R2 reset sync_n", sync_n, 0);
    chk(cgs_done == 1'b0 && ilas_wait == 1'b0, "R9 reset flags", {cgs_done, ilas_wait}, 0);

    // R1: waits for lmfc_valid even with commas present
    rst = 1'b0; link_en = 1'b1; lmfc_valid = 1'b0;
    for (int i = 0; i < 6; i++) tick(comma_of(i, 0));
    chk(dbg_state == 3'd0, "R1 idle without lmfc_valid", dbg_state, 0);
    chk(sync_n == 1'b0, "R2 idle sync_n", sync_n, 0);
    lmfc_valid = 1'b1;
    tick(10'd0);
    chk(dbg_state == 3'd1, "R1 enter search", dbg_state, 1);

    // sweep over offsets and starting disparity
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 10; s++) begin
        clear_stream();
        for (int m = 0; m < 12; m++) put_char(s + 10 * m, comma_of(m, d));
        restart();
        for (int n = 0; n < 4; n++) tick(word_at(n));
        chk(cgs_done == 1'b0, $sformatf("R5 no done after three s=%0d d=%0d", s, d), cgs_done, 0);
        chk(dbg_state == 3'd2, "R3 count state", dbg_state, 2);
        chk(align_ofs == 4'(s), "R3 offset locked", align_ofs, s);
        tick(word_at(4));
        chk(cgs_done == 1'b1, $sformatf("R5 done after four s=%0d d=%0d", s, d), cgs_done, 1);
        chk(dbg_state == 3'd3, "R5 lmfc wait state", dbg_state, 3);
        chk(aligned_char == comma_of(3, d), $sformatf("R4 aligned char s=%0d", s), aligned_char, comma_of(3, d));
        chk(sync_n == 1'b0, "R5 sync held before lmfc", sync_n, 0);
        tick(word_at(5)); tick(word_at(6));
        chk(sync_n == 1'b0 && dbg_state == 3'd3, "R5 hold without lmfc_edge", sync_n, 0);
        lmfc_edge = 1'b1;
        tick(word_at(7));
        lmfc_edge = 1'b0;
        chk(sync_n == 1'b1, "R8 sync released", sync_n, 1);
        chk(ilas_wait == 1'b1 && dbg_state == 3'd4, "R8 ilas wait", dbg_state, 4);
        tick(word_at(8));
        chk(ilas_wait == 1'b1 && sync_n == 1'b1, "R8 ilas hold", ilas_wait, 1);
        link_en = 1'b0;
        tick(word_at(9));
        chk(dbg_state == 3'd0 && sync_n == 1'b0 && cgs_done == 1'b0 && ilas_wait == 1'b0,
            "R9 link_en low returns idle", dbg_state, 0);
      end
    end

    // R6: non-comma word breaks the run
    clear_stream();
    put_char(0, KN); put_char(10, KP); put_char(20, KN);
    for (int m = 0; m < 6; m++) put_char(40 + 10 * m, comma_of(m, 1));
    restart();
    for (int n = 0; n < 8; n++) tick(word_at(n));
    chk(cgs_done == 1'b0 && dbg_state == 3'd2, "R6 run restarted", cgs_done, 0);
    tick(word_at(8));
    chk(cgs_done == 1'b1, "R6 done after four new commas", cgs_done, 1);

    // R7: comma at a new offset re-selects alignment
    clear_stream();
    put_char(0, KN); put_char(10, KP); put_char(20, KN);
    for (int m = 0; m < 7; m++) put_char(33 + 10 * m, comma_of(m, 1));
    restart();
    for (int n = 0; n < 5; n++) tick(word_at(n));
    chk(align_ofs == 4'd3 && dbg_state == 3'd2, "R7 offset re-selected", align_ofs, 3);
    tick(word_at(5)); tick(word_at(6)); tick(word_at(7));
    chk(cgs_done == 1'b0, "R7 count zeroed on relock", cgs_done, 0);
    tick(word_at(8));
    chk(cgs_done == 1'b1 && align_ofs == 4'd3, "R7 done at new offset", align_ofs, 3);

    // R9: synchronous reset mid-count
    clear_stream();
    for (int m = 0; m < 6; m++) put_char(10 * m, comma_of(m, 0));
    restart();
    tick(word_at(0)); tick(word_at(1)); tick(word_at(2));
    rst = 1'b1;
    tick(word_at(3));
    chk(dbg_state == 3'd0 && sync_n == 1'b0 && cgs_done == 1'b0, "R9 reset mid count", dbg_state, 0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule